// File: doc/BRIEF.md
# Dual-Source UART Receive Merger

This block receives serial characters on two separate UART input pins: one wired to an on-board host processor, the other to a debug connector. Each pin has its own complete receiver. The two receivers feed a merge stage that presents one byte bus with a single-clock valid strobe. Downstream logic therefore sees one character stream, and neither link needs a strap, jumper or configuration bit to enable it.

Source selection is automatic. The host receiver's own character-complete pulse steers the output multiplexer. The two completion pulses are ORed to form the merged strobe. A registered source flag records which pin supplied the latest byte, so a transmit path can send its replies back out of the matching pin.

The oversampling divisor (clocks per oversample tick), the oversampling ratio and the character width are parameters. Both receivers share them.

Top module: `dual_rx_merge`

## Requirements
- R1: Each pin is received as 8N1: one low start bit, then 8 data bits least-significant first, then one high stop bit. One bit lasts OVERSAMPLE*CLKS_PER_TICK clocks, and every bit is sampled near its centre.
- R2: Each correctly framed character produces exactly one merged valid pulse, one clock wide.
- R3: The merged valid is the OR of the two receivers' completion pulses. A character on either pin appears on outByte in the cycle that outValid is high.
- R4: srcId is 0 when the last delivered byte came from rxHost and 1 when it came from rxDebug. It changes only in cycles where outValid is high and holds its value in between.
- R5: If both receivers complete in the same cycle, the rxHost byte is delivered with srcId 0. collision is high for exactly that one cycle, only one valid pulse is produced, and the rxDebug byte is dropped.
- R6: A low pulse shorter than half a bit period is rejected as a false start. It produces no valid pulse and no frame error, and the receiver still accepts the next character normally.
- R7: A character whose stop bit is sampled low produces a one-clock pulse on frameErr for that pin (bit 0 = rxHost, bit 1 = rxDebug) and no valid pulse. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: After the synchronous active-high reset, outValid, collision, frameErr, srcId and outByte are all 0.
- R9: While both lines idle high, no valid, collision or frame-error pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxHost | input | 1 | Serial input from the on-board host, idles high |
| rxDebug | input | 1 | Serial input from the debug connector, idles high |
| outByte | output | 8 | Merged received character |
| outValid | output | 1 | One-clock strobe marking a new character on outByte |
| srcId | output | 1 | Pin that supplied the last character (0 host, 1 debug) |
| collision | output | 1 | Both receivers completed in the same cycle |
| frameErr | output | 2 | Per-pin stop-bit error pulse |

## Verification
The two functions that can fall in the same cycle are the completion of a host character and the completion of a debug character. The bench provokes this by driving identical bit timing on both pins at once, so both receivers finish on the same clock. It also uses several different byte pairs. The expected result is one valid pulse carrying the host byte, srcId 0 and exactly one collision cycle. Single-pin traffic across all 256 byte values, alternating between the pins, confirms that the merge and the source flag behave correctly when there is no collision.

// File: rtl/uart_merge_pkg.sv
package uart_merge_pkg;
  typedef struct packed {
    logic shiftEn;  // sample current line level into the shift register
    logic deliver;  // stop bit good: publish the byte
    logic badStop;  // stop bit low: flag framing error
  } rxStrobe_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rxState_t;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import uart_merge_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVERSAMPLE    = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rxLine,
  output rxStrobe_t strobes
);
  localparam int DIV_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int S_W   = $clog2(OVERSAMPLE);
  localparam int B_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_TICK - 1);
  localparam logic [S_W-1:0]   S_HALF   = S_W'(OVERSAMPLE / 2 - 1);
  localparam logic [S_W-1:0]   S_LAST   = S_W'(OVERSAMPLE - 1);
  localparam logic [B_W-1:0]   B_LAST   = B_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [S_W-1:0]   sCnt;
  logic [B_W-1:0]   bitCnt;
  logic             tick;
  logic             atEnd;

  assign tick  = (divCnt == DIV_LAST);
  assign atEnd = tick && (sCnt == S_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      divCnt <= '0;
      sCnt   <= '0;
      bitCnt <= '0;
    end else begin
      if (state == RX_IDLE || state == RX_BREAK) divCnt <= '0;
      else divCnt <= tick ? '0 : divCnt + 1'b1;

      case (state)
        RX_IDLE: begin
          sCnt   <= '0;
          bitCnt <= '0;
          if (!rxLine) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (sCnt == S_HALF) begin
            sCnt  <= '0;
            state <= rxLine ? RX_IDLE : RX_DATA;
          end else sCnt <= sCnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (sCnt == S_LAST) begin
            sCnt   <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == B_LAST) state <= RX_STOP;
          end else sCnt <= sCnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (sCnt == S_LAST) begin
            sCnt  <= '0;
            state <= rxLine ? RX_IDLE : RX_BREAK;
          end else sCnt <= sCnt + 1'b1;
        end
        RX_BREAK: if (rxLine) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shiftEn = (state == RX_DATA) && atEnd;
    strobes.deliver = (state == RX_STOP) && atEnd && rxLine;
    strobes.badStop = (state == RX_STOP) && atEnd && !rxLine;
  end

  // R7: a low stop bit parks the receiver until the line is released
  assert_break_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (state == RX_BREAK && !rxLine) |=> (state == RX_BREAK));

  // R6: the start check leaves for IDLE whenever the line is high at mid-bit
  assert_false_start_R6: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && tick && sCnt == S_HALF && rxLine) |=> (state == RX_IDLE));
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import uart_merge_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxPin,
  input  rxStrobe_t            strobes,
  output logic                 rxLine,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 validOut,
  output logic                 frameErr
);
  logic                 syncA;
  logic                 syncB;
  logic [DATA_BITS-1:0] shReg;

  assign rxLine = syncB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      shReg    <= '0;
      dataOut  <= '0;
      validOut <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      syncA    <= rxPin;
      syncB    <= syncA;
      if (strobes.shiftEn) shReg <= {syncB, shReg[DATA_BITS-1:1]};
      if (strobes.deliver) dataOut <= shReg;
      validOut <= strobes.deliver;
      frameErr <= strobes.badStop;
    end
  end

  // R2: completion pulse is a single clock wide
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  // R7: a character is either delivered or flagged, never both
  assert_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(validOut && frameErr));
endmodule

// File: rtl/merge_unit.sv
module merge_unit #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hostValid,
  input  logic [DATA_BITS-1:0] hostByte,
  input  logic                 dbgValid,
  input  logic [DATA_BITS-1:0] dbgByte,
  output logic [DATA_BITS-1:0] outByte,
  output logic                 outValid,
  output logic                 srcId,
  output logic                 collision
);
  logic anyValid;
  assign anyValid = hostValid | dbgValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      outByte   <= '0;
      outValid  <= 1'b0;
      srcId     <= 1'b0;
      collision <= 1'b0;
    end else begin
      outValid  <= anyValid;
      collision <= hostValid & dbgValid;
      if (anyValid) begin
        outByte <= hostValid ? hostByte : dbgByte;
        srcId   <= ~hostValid;
      end
    end
  end

  // R5: collision only accompanies a delivered byte
  assert_collision_valid_R5: assert property (@(posedge clk) disable iff (rst)
    collision |-> (outValid && !srcId));

  // R4: a lone debug character is routed with srcId 1
  assert_debug_route_R4: assert property (@(posedge clk) disable iff (rst)
    (dbgValid && !hostValid) |=> (outValid && srcId && outByte == $past(dbgByte)));

  // R4: source flag holds between deliveries
  assert_src_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(srcId));
endmodule

// File: rtl/dual_rx_merge.sv
module dual_rx_merge
  import uart_merge_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVERSAMPLE    = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxHost,
  input  logic                 rxDebug,
  output logic [DATA_BITS-1:0] outByte,
  output logic                 outValid,
  output logic                 srcId,
  output logic                 collision,
  output logic [1:0]           frameErr
);
  localparam int N_CH = 2;

  logic [N_CH-1:0]      rxPins;
  logic [N_CH-1:0]      chLine;
  logic [N_CH-1:0]      chValid;
  logic [DATA_BITS-1:0] chByte [N_CH];
  rxStrobe_t            chStrobe [N_CH];

  assign rxPins = {rxDebug, rxHost};

  for (genvar g = 0; g < N_CH; g++) begin : gen_ch
    rx_ctrl #(
      .CLKS_PER_TICK(CLKS_PER_TICK),
      .OVERSAMPLE   (OVERSAMPLE),
      .DATA_BITS    (DATA_BITS)
    ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .rxLine (chLine[g]),
      .strobes(chStrobe[g])
    );

    rx_datapath #(
      .DATA_BITS(DATA_BITS)
    ) u_dp (
      .clk     (clk),
      .rst     (rst),
      .rxPin   (rxPins[g]),
      .strobes (chStrobe[g]),
      .rxLine  (chLine[g]),
      .dataOut (chByte[g]),
      .validOut(chValid[g]),
      .frameErr(frameErr[g])
    );
  end

  merge_unit #(
    .DATA_BITS(DATA_BITS)
  ) u_merge (
    .clk      (clk),
    .rst      (rst),
    .hostValid(chValid[0]),
    .hostByte (chByte[0]),
    .dbgValid (chValid[1]),
    .dbgByte  (chByte[1]),
    .outByte  (outByte),
    .outValid (outValid),
    .srcId    (srcId),
    .collision(collision)
  );
endmodule

// File: tb/tb_dual_rx_merge.sv
module tb_dual_rx_merge;
  localparam int CPT = 2;
  localparam int OS  = 16;
  localparam int BIT = CPT * OS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxHost = 1'b1;
  logic       rxDebug = 1'b1;
  logic [7:0] outByte;
  logic       outValid;
  logic       srcId;
  logic       collision;
  logic [1:0] frameErr;

  int checks = 0;
  int fails = 0;
  int validCnt = 0;
  int collCnt = 0;
  int ferr0 = 0;
  int ferr1 = 0;
  logic [7:0] lastByte = '0;
  logic       lastSrc = 1'b0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  dual_rx_merge #(.CLKS_PER_TICK(CPT), .OVERSAMPLE(OS), .DATA_BITS(8)) dut (
    .clk(clk), .rst(rst), .rxHost(rxHost), .rxDebug(rxDebug),
    .outByte(outByte), .outValid(outValid), .srcId(srcId),
    .collision(collision), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        validCnt++;
        lastByte = outByte;
        lastSrc  = srcId;
      end
      if (collision) collCnt++;
      if (frameErr[0]) ferr0++;
      if (frameErr[1]) ferr1++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic useHost, input logic useDbg,
                           input logic [7:0] hb, input logic [7:0] db,
                           input logic hStop, input logic dStop);
    logic [9:0] hf;
    logic [9:0] df;
    hf = {hStop, hb, 1'b0};
    df = {dStop, db, 1'b0};
    for (int b = 0; b < 10; b++) begin
      rxHost  = useHost ? hf[b] : 1'b1;
      rxDebug = useDbg  ? df[b] : 1'b1;
      repeat (BIT) @(negedge clk);
    end
    rxHost  = 1'b1;
    rxDebug = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int v0, c0, e0, e1;
    logic [7:0] hb, db;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check("R8 outValid", outValid, 0);
    check("R8 collision", collision, 0);
    check("R8 frameErr", frameErr, 0);
    check("R8 srcId", srcId, 0);
    check("R8 outByte", outByte, 0);

    // R9: idle lines give nothing
    repeat (500) @(negedge clk);
    check("R9 valid count", validCnt, 0);
    check("R9 collision count", collCnt, 0);
    check("R9 frameErr count", ferr0 + ferr1, 0);

    // R1 R2 R3 R4: every byte value, alternating pins
    for (int i = 0; i < 256; i++) begin
      v0 = validCnt;
      c0 = collCnt;
      if (i % 2 == 0) sendFrame(1'b1, 1'b0, 8'(i), 8'h00, 1'b1, 1'b1);
      else            sendFrame(1'b0, 1'b1, 8'h00, 8'(i), 1'b1, 1'b1);
      check("R2 one valid per char", validCnt, v0 + 1);
      check("R1 byte value", lastByte, i);
      check("R4 srcId", lastSrc, i % 2);
      check("R3 no collision", collCnt, c0);
    end
    // R4: flag holds while idle after a debug char
    repeat (200) @(negedge clk);
    check("R4 srcId hold", srcId, 1);

    // R5: simultaneous arrival, several byte pairs
    for (int k = 0; k < 4; k++) begin
      hb = 8'(8'hA5 ^ (k * 8'h37));
      db = 8'(8'h3C + k * 8'h51);
      v0 = validCnt;
      c0 = collCnt;
      sendFrame(1'b1, 1'b1, hb, db, 1'b1, 1'b1);
      check("R5 single valid", validCnt, v0 + 1);
      check("R5 host byte wins", lastByte, hb);
      check("R5 srcId host", lastSrc, 0);
      check("R5 one collision cycle", collCnt, c0 + 1);
    end

    // R6: short glitch on each pin
    for (int p = 0; p < 2; p++) begin
      v0 = validCnt;
      e0 = ferr0 + ferr1;
      if (p == 0) rxHost = 1'b0; else rxDebug = 1'b0;
      repeat (6) @(negedge clk);
      rxHost  = 1'b1;
      rxDebug = 1'b1;
      repeat (100) @(negedge clk);
      check("R6 glitch no valid", validCnt, v0);
      check("R6 glitch no frameErr", ferr0 + ferr1, e0);
      sendFrame(p == 0, p == 1, 8'h5A, 8'h5A, 1'b1, 1'b1);
      check("R6 recovers", validCnt, v0 + 1);
      check("R6 recovered byte", lastByte, 8'h5A);
    end

    // R7: low stop bit on each pin
    v0 = validCnt;
    e0 = ferr0;
    e1 = ferr1;
    sendFrame(1'b0, 1'b1, 8'h00, 8'hC3, 1'b1, 1'b0);
    check("R7 debug no valid", validCnt, v0);
    check("R7 debug frameErr", ferr1, e1 + 1);
    check("R7 host untouched", ferr0, e0);
    sendFrame(1'b1, 1'b0, 8'h96, 8'h00, 1'b0, 1'b1);
    check("R7 host no valid", validCnt, v0);
    check("R7 host frameErr", ferr0, e0 + 1);
    sendFrame(1'b0, 1'b1, 8'h00, 8'h7E, 1'b1, 1'b1);
    check("R7 next char ok", validCnt, v0 + 1);
    check("R7 next byte", lastByte, 8'h7E);
    check("R7 next src", lastSrc, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule